// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block sits in the fetch stage of a five-stage pipeline. It chooses the address fetched in the next cycle. It keeps a small direct-mapped table of taken branches, and each entry pairs a branch address with the address that branch last jumped to. Each cycle the current fetch address is looked up in the table. On a hit the stored target becomes the next fetch address. On a miss the next address is the fetch address plus four.

Branches resolve a cycle or so later, in the decode stage. The resolution port reports the branch address, whether the branch was taken and where it went. A taken branch is written into the table. A not-taken branch that is in the table is removed from it. The block looks up the resolving branch in its own table to find out what it predicted for that branch. If the prediction was wrong, in direction or in target, it raises a flush so the wrong-path instruction already fetched becomes a no-op. In that same cycle it also steers fetch to the corrected address, so a mispredict costs a single cycle.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, so no fetch address hits: pred_hit is 0 and next_pc equals fetch_pc + 4.
- R2: A resolution with res_valid=1 and res_taken=1 writes an entry at index res_pc[5:2], tagged with res_pc[31:6], holding res_target. The entry is visible to fetch from the following cycle.
- R3: When fetch_pc matches a valid entry (same index bits [5:2] and same tag bits [31:6]), pred_hit is 1 and next_pc is the stored target, in the same cycle.
- R4: When fetch_pc misses and no flush is raised, next_pc is fetch_pc + 4.
- R5: A resolution with res_taken=0 whose res_pc matches a valid entry invalidates that entry. A not-taken resolution whose res_pc does not match leaves the table unchanged, including any entry that holds another tag at the same index.
- R6: flush is 1 in the cycle of a valid resolution exactly when the table's prediction for res_pc was wrong. That means one of three cases: a hit and not taken, a miss and taken, or a hit and taken with a stored target that differs from res_target.
- R7: While flush is 1, next_pc is res_target when res_taken=1 and res_pc + 4 otherwise. This overrides the fetch-side prediction of the same cycle.
- R8: A resolution that agrees with the prediction raises no flush: a hit with matching target and taken, or a miss and not taken.
- R9: A taken branch that maps to an index already holding a different tag replaces that entry, so the earlier branch misses afterwards.
- R10: flush is 0 whenever res_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset, clears all entries |
| fetch_pc | input | 32 | Address being fetched this cycle |
| next_pc | output | 32 | Address to fetch in the next cycle |
| pred_hit | output | 1 | fetch_pc matched a valid entry |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | 32 | Address of the resolving branch |
| res_taken | input | 1 | The resolving branch was taken |
| res_target | input | 32 | Actual target of the resolving branch |
| flush | output | 1 | Prediction was wrong; squash the wrong-path fetch |

## Verification
Several behaviours are checked by assertions on every cycle. A taken resolution makes the same address hit with its target on the next cycle. A not-taken resolution makes that address miss on the next cycle. Whenever a flush is raised, next_pc carries the corrected address, and a flush never appears without a resolution. Other behaviours can only be shown by the bench's scenarios and its reference model: the empty table after reset, replacement of an aliasing entry, a not-taken resolution that leaves an aliased entry untouched, and the exact conditions under which a flush is or is not raised.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int PC_W = 32;
  typedef logic [PC_W-1:0] pc_t;

  // sequential successor of a word-aligned instruction address
  function automatic pc_t pc_step(input pc_t pc);
    return pc + pc_t'(4);
  endfunction

  // selection of the redirect address once a branch outcome is known
  function automatic pc_t repair_pc(input pc_t br_pc, input logic taken, input pc_t tgt);
    return taken ? tgt : pc_step(br_pc);
  endfunction
endpackage

// File: rtl/btb_table.sv
module btb_table
  import btb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int TAG_W   = PC_W - IDX_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  pc_t              wr_tgt,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic             rd_a_vld,
  output logic [TAG_W-1:0] rd_a_tag,
  output pc_t              rd_a_tgt,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic             rd_b_vld,
  output logic [TAG_W-1:0] rd_b_tag,
  output pc_t              rd_b_tgt
);
  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  pc_t                tgt_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic hit_wr, hit_inv;
    assign hit_wr  = wr_en  && (wr_idx  == IDX_W'(e));
    assign hit_inv = inv_en && (inv_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[e] <= 1'b0;
      end else if (hit_wr) begin
        vld_q[e] <= 1'b1;
      end else if (hit_inv) begin
        vld_q[e] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_q[e] <= '0;
        tgt_q[e] <= '0;
      end else if (hit_wr) begin
        tag_q[e] <= wr_tag;
        tgt_q[e] <= wr_tgt;
      end
    end
  end

  assign rd_a_vld = vld_q[rd_a_idx];
  assign rd_a_tag = tag_q[rd_a_idx];
  assign rd_a_tgt = tgt_q[rd_a_idx];
  assign rd_b_vld = vld_q[rd_b_idx];
  assign rd_b_tag = tag_q[rd_b_idx];
  assign rd_b_tgt = tgt_q[rd_b_idx];
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
  import btb_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = PC_W - IDX_W - 2
) (
  input  pc_t              pc,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag,
  input  logic             ent_vld,
  input  logic [TAG_W-1:0] ent_tag,
  input  pc_t              ent_tgt,
  output logic             hit,
  output pc_t              tgt
);
  logic [1:0] unused_lo;
  assign unused_lo = pc[1:0];

  assign idx = pc[IDX_W+1:2];
  assign tag = pc[PC_W-1:IDX_W+2];
  assign hit = ent_vld && (ent_tag == tag);
  assign tgt = ent_tgt;
endmodule

// File: rtl/btb_redirect.sv
module btb_redirect
  import btb_pkg::*;
(
  input  pc_t  fetch_pc,
  input  logic fetch_hit,
  input  pc_t  fetch_tgt,
  input  logic res_valid,
  input  pc_t  res_pc,
  input  logic res_taken,
  input  pc_t  res_target,
  input  logic res_hit,
  input  pc_t  res_pred_tgt,
  output logic dir_wrong,
  output logic tgt_wrong,
  output logic mispredict,
  output pc_t  next_pc
);
  pc_t predicted;

  assign dir_wrong  = res_valid && (res_hit != res_taken);
  assign tgt_wrong  = res_valid && res_hit && res_taken && (res_pred_tgt != res_target);
  assign mispredict = dir_wrong || tgt_wrong;
  assign predicted  = fetch_hit ? fetch_tgt : pc_step(fetch_pc);
  assign next_pc    = mispredict ? repair_pc(res_pc, res_taken, res_target) : predicted;
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] fetch_pc,
  output logic [31:0] next_pc,
  output logic        pred_hit,
  input  logic        res_valid,
  input  logic [31:0] res_pc,
  input  logic        res_taken,
  input  logic [31:0] res_target,
  output logic        flush
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W - 2;

  logic [IDX_W-1:0] f_idx, r_idx;
  logic [TAG_W-1:0] f_tag, r_tag, f_ent_tag, r_ent_tag;
  logic             f_ent_vld, r_ent_vld, f_hit, r_hit;
  pc_t              f_ent_tgt, r_ent_tgt, f_tgt, r_tgt;
  logic             learn_en, forget_en, dir_wrong, tgt_wrong, mispredict;

  btb_lookup #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_flook (
    .pc(fetch_pc), .idx(f_idx), .tag(f_tag),
    .ent_vld(f_ent_vld), .ent_tag(f_ent_tag), .ent_tgt(f_ent_tgt),
    .hit(f_hit), .tgt(f_tgt)
  );

  btb_lookup #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_rlook (
    .pc(res_pc), .idx(r_idx), .tag(r_tag),
    .ent_vld(r_ent_vld), .ent_tag(r_ent_tag), .ent_tgt(r_ent_tgt),
    .hit(r_hit), .tgt(r_tgt)
  );

  assign learn_en  = res_valid && res_taken;
  assign forget_en = res_valid && !res_taken && r_hit;

  btb_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(learn_en), .wr_idx(r_idx), .wr_tag(r_tag), .wr_tgt(res_target),
    .inv_en(forget_en), .inv_idx(r_idx),
    .rd_a_idx(f_idx), .rd_a_vld(f_ent_vld), .rd_a_tag(f_ent_tag), .rd_a_tgt(f_ent_tgt),
    .rd_b_idx(r_idx), .rd_b_vld(r_ent_vld), .rd_b_tag(r_ent_tag), .rd_b_tgt(r_ent_tgt)
  );

  btb_redirect u_redir (
    .fetch_pc(fetch_pc), .fetch_hit(f_hit), .fetch_tgt(f_tgt),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target), .res_hit(r_hit), .res_pred_tgt(r_tgt),
    .dir_wrong(dir_wrong), .tgt_wrong(tgt_wrong), .mispredict(mispredict),
    .next_pc(next_pc)
  );

  assign pred_hit = f_hit;
  assign flush    = mispredict;
endmodule

// File: rtl/btb_checker.sv
module btb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] fetch_pc,
  input logic [31:0] next_pc,
  input logic        pred_hit,
  input logic        res_valid,
  input logic [31:0] res_pc,
  input logic        res_taken,
  input logic [31:0] res_target,
  input logic        flush
);
  AST_LEARN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_taken) |=>
      ((fetch_pc != $past(res_pc)) || flush || (pred_hit && next_pc == $past(res_target)))); // R2

  AST_FORGET_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_taken) |=> ((fetch_pc != $past(res_pc)) || !pred_hit)); // R5

  AST_REPAIR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && res_taken) |-> (next_pc == res_target)); // R7

  AST_REPAIR_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !res_taken) |-> (next_pc == res_pc + 32'd4)); // R7

  AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !pred_hit) |-> (next_pc == fetch_pc + 32'd4)); // R4

  AST_FLUSH_NEEDS_RES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> res_valid); // R10
endmodule

bind btb_predictor btb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .next_pc(next_pc),
  .pred_hit(pred_hit), .res_valid(res_valid), .res_pc(res_pc),
  .res_taken(res_taken), .res_target(res_target), .flush(flush)
);

// File: tb/sim_btb_predictor.sv
`timescale 1ns/1ps
module sim_btb_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0, res_pc = '0, res_target = '0;
  logic        res_valid = 1'b0, res_taken = 1'b0;
  logic [31:0] next_pc;
  logic        pred_hit, flush;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural model: taken branches keyed by full address
  logic [31:0] known [logic [31:0]];

  always #2 clk = ~clk;

  btb_predictor u0 (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .next_pc(next_pc),
    .pred_hit(pred_hit), .res_valid(res_valid), .res_pc(res_pc),
    .res_taken(res_taken), .res_target(res_target), .flush(flush)
  );

  function automatic bit same_slot(input logic [31:0] a, input logic [31:0] b);
    return ((a >> 2) % 16) == ((b >> 2) % 16);
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, compare before the rising edge, then update the model
  task automatic step(input string req, input logic [31:0] fpc, input bit rv,
                      input logic [31:0] rpc, input bit rt, input logic [31:0] rtgt);
    bit hit_f, hit_r, wrong;
    logic [31:0] exp_next;
    @(negedge clk);
    fetch_pc = fpc; res_valid = rv; res_pc = rpc; res_taken = rt; res_target = rtgt;
    #1;
    hit_f = known.exists(fpc);
    hit_r = known.exists(rpc);
    wrong = rv && ((hit_r != rt) || (rt && hit_r && known[rpc] != rtgt));
    if (wrong) exp_next = rt ? rtgt : rpc + 32'd4;
    else if (hit_f) exp_next = known[fpc];
    else exp_next = fpc + 32'd4;
    check(req, "next_pc", next_pc, exp_next);
    check(req, "pred_hit", {31'd0, pred_hit}, {31'd0, hit_f});
    check(req, "flush", {31'd0, flush}, {31'd0, wrong});
    if (rv && rt) begin
      logic [31:0] victims [$];
      foreach (known[k]) if (same_slot(k, rpc)) victims.push_back(k);
      foreach (victims[v]) known.delete(victims[v]);
      known[rpc] = rtgt;
    end else if (rv && hit_r) begin
      known.delete(rpc);
    end
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: empty table after reset
    step("R1", 32'h0000_1000, 0, 0, 0, 0);
    step("R1", 32'h0000_103C, 0, 0, 0, 0);
    // R4: sequential on miss
    step("R4", 32'h0040_0020, 0, 0, 0, 0);
    // R6: miss and taken -> flush; R7 repair to target; R2 learn
    step("R6_R7", 32'h0000_2000, 1, 32'h0000_1008, 1, 32'h0000_3000);
    // R3: hit supplies target next cycle
    step("R3", 32'h0000_1008, 0, 0, 0, 0);
    // R8: agreeing resolution, no flush
    step("R8", 32'h0000_3000, 1, 32'h0000_1008, 1, 32'h0000_3000);
    step("R8", 32'h0000_3004, 1, 32'h0000_5000, 0, 0);
    // R6: target changed -> flush, new target learned
    step("R6", 32'h0000_3004, 1, 32'h0000_1008, 1, 32'h0000_4440);
    step("R3", 32'h0000_1008, 0, 0, 0, 0);
    // R7: flush overrides a fetch hit in the same cycle
    step("R7", 32'h0000_1008, 1, 32'h0000_2224, 1, 32'h0000_9000);
    // R9: alias at same index replaces
    step("R9", 32'h0000_0100, 1, 32'h0001_0008, 1, 32'h0000_7770);
    step("R9", 32'h0000_1008, 0, 0, 0, 0);
    step("R9", 32'h0001_0008, 0, 0, 0, 0);
    // R5: not-taken with another tag at the index leaves it intact
    step("R5", 32'h0000_0200, 1, 32'h0000_1008, 0, 0);
    step("R5", 32'h0001_0008, 0, 0, 0, 0);
    // R5: not-taken on a hit flushes and invalidates
    step("R5_R6", 32'h0000_0300, 1, 32'h0001_0008, 0, 0);
    step("R5", 32'h0001_0008, 0, 0, 0, 0);
    // R10: no resolution, no flush
    step("R10", 32'h0000_2224, 0, 32'h0000_2224, 0, 32'h0000_1234);
    // mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a, b, t;
      a = {28'($urandom_range(0, 3) << 4), 2'b00, 2'b00} | (32'($urandom_range(0, 15)) << 2);
      b = {28'($urandom_range(0, 3) << 4), 2'b00, 2'b00} | (32'($urandom_range(0, 15)) << 2);
      t = 32'($urandom_range(0, 7)) << 8;
      step("R6_R8_mix", a, $urandom_range(0, 1) == 1, b, $urandom_range(0, 1) == 1, t);
    end
    // R1: reset clears learned entries
    known.delete();
    @(negedge clk); rst_n = 1'b0; res_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    step("R1", 32'h0000_2224, 0, 0, 0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule